// File: doc/BRIEF.md
# Vectored Interrupt Controller with Register Bus

This block gathers a parameterised number of interrupt sources (up to 32) into one interrupt request line for a processor. Each source is fixed at build time as either edge-sensed or level-sensed. When a source fires, it sets a latched status bit. Software reaches the block over a small 32-bit register bus. Through that bus it enables sources, acknowledges them and reads back which source to service next.

Each register sits at a word index on a 3-bit word address; the byte offset is the index times four. The indices are:

| Index | Register |
|-------|----------|
| 0 | status |
| 1 | pending |
| 2 | enable |
| 3 | acknowledge |
| 4 | set-enable |
| 5 | clear-enable |
| 6 | vector |
| 7 | master control |

Enable bits can be changed atomically through the set-enable and clear-enable aliases, without a read-modify-write. A two-bit master control register has two bits:
- bit 0 gates the request output;
- bit 1 lets the hardware sources reach the status bits.

Read data is registered and is valid in the cycle after the read strobe. Bits above the source count read as zero.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, every register reads zero, the vector register reads 0xFFFFFFFF and the request output is low.
- R2: A write to the enable register (index 2) replaces all enable bits, and a read of index 2 returns them.
- R3: A write to set-enable (index 4) sets each enable bit whose write-data bit is 1 and leaves the enable bits under 0 write-data bits unchanged. Reads of index 4 return zero.
- R4: A write to clear-enable (index 5) clears each enable bit whose write-data bit is 1 and leaves the others unchanged.
- R5: A level-sensed source (EDGE_MASK bit 0) sets its status bit on each clock edge at which it is high. If it is still high when acknowledged, the status bit stays set.
- R6: An edge-sensed source (EDGE_MASK bit 1) sets its status bit only on a low-to-high transition. The bit stays set after the input falls, until it is acknowledged. An input that is held high does not set the bit again after an acknowledge.
- R7: A write to acknowledge (index 3) clears each status bit whose write-data bit is 1. Writing all ones clears every latched edge-sensed bit.
- R8: The pending register (index 1) reads as the bitwise AND of status and enable.
- R9: The request output is high exactly when master bit 0 is set and at least one pending bit is 1.
- R10: The vector register (index 6) reads as the lowest-numbered pending source index, or 0xFFFFFFFF when nothing is pending.
- R11: Master bit 0 is freely writable. While master bit 1 is clear, sources set no status bits. Once master bit 1 is set, software cannot clear it again.
- R12: Writes to status (index 0), pending (index 1) and vector (index 6) change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| src_i | input | NUM_SRC | Interrupt sources, synchronous to clk_i |
| waddr_i | input | 3 | Register word index |
| wdata_i | input | 32 | Write data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Registered read data, valid the cycle after rd_i |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
A source change or a register write takes effect at the next rising edge. From that edge on, the request output follows with no further delay, because it is decoded from registered state. Read data lands one edge after the read strobe. The bench therefore drives at falling edges and issues each read one falling edge after the stimulus has been clocked in. It compares the read result at the falling edge that follows the capturing rising edge. Request checks are sampled at a falling edge after the relevant write or source edge has been registered.

// File: rtl/ivc_pkg.sv
package ivc_pkg;

    typedef enum logic [2:0] {
        RS_STAT = 3'd0,
        RS_PEND = 3'd1,
        RS_EN   = 3'd2,
        RS_ACK  = 3'd3,
        RS_SET  = 3'd4,
        RS_CLR  = 3'd5,
        RS_VEC  = 3'd6,
        RS_MER  = 3'd7
    } reg_sel_e;

    localparam int unsigned MER_OUT_BIT = 0;
    localparam int unsigned MER_HW_BIT  = 1;
    localparam int unsigned BUS_W       = 32;

endpackage

// File: rtl/ivc_sense.sv
module ivc_sense #(
    parameter int unsigned NUM_SRC   = 32,
    parameter logic [31:0] EDGE_MASK = 32'h0
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] src_i,
    output logic [NUM_SRC-1:0] hit_o
);

    logic [NUM_SRC-1:0] src_d, src_q;

    always_comb begin
        src_d = src_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) src_q <= '0;
        else         src_q <= src_d;
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        if (EDGE_MASK[i]) begin : g_edge
            assign hit_o[i] = src_i[i] & ~src_q[i];
        end else begin : g_level
            assign hit_o[i] = src_i[i];
        end
    end

endmodule

// File: rtl/ivc_prio.sv
module ivc_prio #(
    parameter int unsigned NUM_SRC = 32,
    parameter int unsigned IDX_W   = 5
) (
    input  logic [NUM_SRC-1:0] pend_i,
    output logic               vld_o,
    output logic [IDX_W-1:0]   idx_o
);

    always_comb begin
        vld_o = 1'b0;
        idx_o = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (pend_i[i]) begin
                vld_o = 1'b1;
                idx_o = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import ivc_pkg::*;
#(
    parameter int unsigned NUM_SRC   = 32,
    parameter logic [31:0] EDGE_MASK = 32'h0
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [2:0]         waddr_i,
    input  logic [31:0]        wdata_i,
    input  logic               wr_i,
    input  logic               rd_i,
    output logic [31:0]        rdata_o,
    output logic               irq_o
);

    localparam int unsigned IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    typedef struct packed {
        logic [NUM_SRC-1:0] stat;
        logic [NUM_SRC-1:0] en;
        logic               out_en;
        logic               hw_en;
        logic [BUS_W-1:0]   rdata;
    } state_t;

    state_t             st_d, st_q;
    reg_sel_e           sel;
    logic [NUM_SRC-1:0] wd;
    logic [NUM_SRC-1:0] ack_clr;
    logic [NUM_SRC-1:0] hit;
    logic [NUM_SRC-1:0] pend;
    logic               vec_vld;
    logic [IDX_W-1:0]   vec_idx;
    logic [BUS_W-1:0]   rd_mux;

    assign sel  = reg_sel_e'(waddr_i);
    assign wd   = wdata_i[NUM_SRC-1:0];
    assign pend = st_q.stat & st_q.en;

    ivc_sense #(
        .NUM_SRC  (NUM_SRC),
        .EDGE_MASK(EDGE_MASK)
    ) i_sense (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .src_i (src_i),
        .hit_o (hit)
    );

    ivc_prio #(
        .NUM_SRC(NUM_SRC),
        .IDX_W  (IDX_W)
    ) i_prio (
        .pend_i(pend),
        .vld_o (vec_vld),
        .idx_o (vec_idx)
    );

    always_comb begin
        case (sel)
            RS_STAT: rd_mux = BUS_W'(st_q.stat);
            RS_PEND: rd_mux = BUS_W'(pend);
            RS_EN:   rd_mux = BUS_W'(st_q.en);
            RS_VEC:  rd_mux = vec_vld ? BUS_W'(vec_idx) : '1;
            RS_MER:  rd_mux = BUS_W'({st_q.hw_en, st_q.out_en});
            default: rd_mux = '0;
        endcase
    end

    always_comb begin
        st_d    = st_q;
        ack_clr = (wr_i && sel == RS_ACK) ? wd : '0;
        // Sources that fire in the same cycle as an acknowledge keep their bit.
        st_d.stat = (st_q.stat & ~ack_clr) | (hit & {NUM_SRC{st_q.hw_en}});
        if (wr_i) begin
            case (sel)
                RS_EN:   st_d.en = wd;
                RS_SET:  st_d.en = st_q.en | wd;
                RS_CLR:  st_d.en = st_q.en & ~wd;
                RS_MER: begin
                    st_d.out_en = wdata_i[MER_OUT_BIT];
                    st_d.hw_en  = st_q.hw_en | wdata_i[MER_HW_BIT];
                end
                default: ;
            endcase
        end
        if (rd_i) st_d.rdata = rd_mux;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign rdata_o = st_q.rdata;
    assign irq_o   = st_q.out_en & vec_vld;

    // Checks on register behaviour over time
    logic [NUM_SRC-1:0] low_mask;
    assign low_mask = (NUM_SRC'(1) << vec_idx) - NUM_SRC'(1);

    assert_set_en_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && sel == RS_SET) |=> ((st_q.en & $past(wd)) == $past(wd)));

    assert_clr_en_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && sel == RS_CLR) |=> ((st_q.en & $past(wd)) == '0));

    assert_ack_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && sel == RS_ACK && !st_q.hw_en) |=> ((st_q.stat & $past(wd)) == '0));

    assert_hw_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.hw_en |=> st_q.hw_en);

    assert_no_src_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !st_q.hw_en |=> ((st_q.stat & ~$past(st_q.stat)) == '0));

    assert_vec_lowest_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        vec_vld |-> (pend[vec_idx] && ((pend & low_mask) == '0)));

    assert_irq_needs_pend_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> (pend != '0));

endmodule

// File: tb/test_irq_vector_ctrl.sv
module test_irq_vector_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NSRC       = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] src = '0;
    logic [2:0]      waddr = '0;
    logic [31:0]     wdata = '0;
    logic            wr = 1'b0;
    logic            rd = 1'b0;
    logic [31:0]     rdata;
    logic            irq;

    always #(CLK_PERIOD / 2) clk = ~clk;

    irq_vector_ctrl #(
        .NUM_SRC  (NSRC),
        .EDGE_MASK(32'h0000_00F0)
    ) i_irq_vector_ctrl (
        .clk_i  (clk),
        .rst_ni (rst_n),
        .src_i  (src),
        .waddr_i(waddr),
        .wdata_i(wdata),
        .wr_i   (wr),
        .rd_i   (rd),
        .rdata_o(rdata),
        .irq_o  (irq)
    );

    int          n_cmp = 0;
    int          n_bad = 0;
    bit          done = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_seen = 1'b0;

    // Monitor: a read captured at a rising edge is compared at the next falling edge.
    always @(posedge clk) rd_seen <= rd;

    always @(negedge clk) begin
        if (rd_seen) begin
            logic [31:0] e;
            string t;
            n_cmp++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL read with no expected item: actual %h expected none", rdata);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rdata !== e) begin
                    n_bad++;
                    $display("FAIL %s: actual %h expected %h", t, rdata, e);
                end
            end
        end
    end

    task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        waddr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        waddr = a; rd = 1'b1;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic set_src(input logic [NSRC-1:0] v);
        @(negedge clk);
        src = v;
    endtask

    task automatic chk_irq(input logic e, input string t);
        @(negedge clk);
        n_cmp++;
        if (irq !== e) begin
            n_bad++;
            $display("FAIL %s irq: actual %b expected %b", t, irq, e);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        rd_reg(3'd0, 32'h0, "R1 status");
        rd_reg(3'd1, 32'h0, "R1 pending");
        rd_reg(3'd2, 32'h0, "R1 enable");
        rd_reg(3'd3, 32'h0, "R1 ack alias");
        rd_reg(3'd4, 32'h0, "R3 set alias reads zero");
        rd_reg(3'd5, 32'h0, "R1 clear alias");
        rd_reg(3'd6, 32'hFFFF_FFFF, "R1 R10 vector idle");
        rd_reg(3'd7, 32'h0, "R1 master");
        chk_irq(1'b0, "R1");

        // R11 sources gated before hardware enable
        set_src(8'h01);
        repeat (2) @(negedge clk);
        rd_reg(3'd0, 32'h0, "R11 status gated");
        wr_reg(3'd7, 32'h1);
        rd_reg(3'd7, 32'h1, "R11 master out only");
        wr_reg(3'd7, 32'h3);
        wr_reg(3'd7, 32'h0);
        rd_reg(3'd7, 32'h2, "R11 hw enable sticky");
        wr_reg(3'd7, 32'h3);
        rd_reg(3'd7, 32'h3, "R11 master both");

        // R5 level source latched, R8 pending masked by enable
        rd_reg(3'd0, 32'h01, "R5 level status");
        rd_reg(3'd1, 32'h00, "R8 pending disabled");
        chk_irq(1'b0, "R9 nothing enabled");

        // R2 direct enable write
        wr_reg(3'd2, 32'h05);
        chk_irq(1'b1, "R9 enabled source");
        rd_reg(3'd2, 32'h05, "R2 enable");
        rd_reg(3'd1, 32'h01, "R8 pending");
        rd_reg(3'd6, 32'h0, "R10 vector 0");

        // R3 / R4 atomic aliases
        wr_reg(3'd4, 32'h0A);
        rd_reg(3'd2, 32'h0F, "R3 set enable");
        wr_reg(3'd5, 32'h05);
        rd_reg(3'd2, 32'h0A, "R4 clear enable");
        chk_irq(1'b0, "R9 after clear");
        rd_reg(3'd6, 32'hFFFF_FFFF, "R10 none pending");

        // R9 master output gate
        wr_reg(3'd7, 32'h2);
        wr_reg(3'd4, 32'h01);
        chk_irq(1'b0, "R9 master off");
        wr_reg(3'd7, 32'h3);
        chk_irq(1'b1, "R9 master on");

        // R5 re-latch while still high, R7 ack after release
        wr_reg(3'd3, 32'h01);
        rd_reg(3'd0, 32'h01, "R5 relatch");
        set_src(8'h00);
        wr_reg(3'd3, 32'h01);
        rd_reg(3'd0, 32'h00, "R7 ack level");
        chk_irq(1'b0, "R9 idle");

        // R6 edge latch survives input falling
        set_src(8'h10);
        set_src(8'h00);
        rd_reg(3'd0, 32'h10, "R6 edge held");
        wr_reg(3'd4, 32'h10);
        rd_reg(3'd6, 32'h4, "R10 vector 4");
        set_src(8'h40);
        set_src(8'h00);
        wr_reg(3'd4, 32'h40);
        rd_reg(3'd0, 32'h50, "R6 two edges");
        rd_reg(3'd6, 32'h4, "R10 lowest wins");
        wr_reg(3'd3, 32'h10);
        rd_reg(3'd6, 32'h6, "R10 next after ack");

        // R6 held-high edge source not re-latched after ack
        set_src(8'h20);
        @(negedge clk);
        rd_reg(3'd0, 32'h60, "R6 edge bit5");
        wr_reg(3'd3, 32'h20);
        @(negedge clk);
        rd_reg(3'd0, 32'h40, "R6 no relatch while high");

        // R7 acknowledge all
        wr_reg(3'd3, 32'hFFFF_FFFF);
        rd_reg(3'd0, 32'h00, "R7 ack all");
        chk_irq(1'b0, "R7 irq cleared");

        // R12 writes to read-only locations
        wr_reg(3'd0, 32'hFF);
        wr_reg(3'd1, 32'hFF);
        wr_reg(3'd6, 32'hFF);
        rd_reg(3'd0, 32'h00, "R12 status unchanged");
        rd_reg(3'd2, 32'h5B, "R12 enable unchanged");
        rd_reg(3'd6, 32'hFFFF_FFFF, "R12 vector unchanged");

        // R8 / R10 several level sources at once
        set_src(8'h26);
        @(negedge clk);
        rd_reg(3'd0, 32'h06, "R5 two level sources");
        rd_reg(3'd1, 32'h02, "R8 masked pending");
        rd_reg(3'd6, 32'h1, "R10 vector 1");
        chk_irq(1'b1, "R9 level pending");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL scoreboard: actual %0d items left expected 0", exp_q.size());
        end
        finish_run();
    end

endmodule